// File: doc/BRIEF.md
# Receive Digital Gain Compensation Stage

This block scales complex receive samples with a digital gain chosen through the current receive gain index. The index may come from an automatic gain loop or from manual control. A gain table holds one entry per index. Each entry carries an analog attenuator code and a small signed trim in half-dB units. The attenuator code is passed to the analog front end. The digital gain is derived from the entry, the index and the selected mode, and is applied equally to I and Q.

The block has two modes. In trim mode the digital gain is just the entry's trim, which evens out uneven analog attenuator steps so that neighbouring indices differ by a uniform 0.5 dB. In cancel mode the digital gain is set to the full attenuation that the index stands for, plus the trim, plus an external gain term in half-dB. Total gain then stays at the nominal receive gain, and an external LNA or step attenuator can be folded out as well. Gains are held as half-dB step counts and turned into a linear multiplier by a twelve-entry mantissa lookup and a power-of-two shift. Results are rounded and saturated.

After reset the table refills itself with a default ramp before samples are accepted. Host writes are accepted only while no sample is presented.

Top module: `rx_gain_comp`

## Requirements
- R1: While `rst` is high, `out_valid`, `out_i`, `out_q`, `att_out` and `tbl_ready` are all 0.
- R2: After `rst` falls, `tbl_ready` rises after exactly 2^IDX_W rising edges, and the table then holds default entries. Entry n has attenuator code 2^IDX_W-1-n and trim 0. A later reset restores these defaults.
- R3: While `tbl_ready` is low, `in_valid` is ignored and no output sample appears.
- R4: A write (`wr_en`=1) with `in_valid`=0 stores `wr_att` and `wr_trim` at `wr_addr`. A write presented while `in_valid`=1 is discarded.
- R5: With `mode`=0 (trim), the gain in half-dB steps is g = trim, read as a TRIM_W-bit two's complement value. `ext_hdb` has no effect.
- R6: With `mode`=1 (cancel), g = (2^IDX_W-1-idx) + trim + ext_hdb, with `ext_hdb` unsigned.
- R7: g is clamped to [-24, 167]. The linear gain is M[(g+24) mod 12] * 2^floor((g+24)/12) / 2^16, with M = 16384, 17358, 18390, 19484, 20643, 21870, 23170, 24548, 26008, 27554, 29193, 30929.
- R8: The product is rounded to the nearest integer, with halves rounded toward plus infinity, and then saturated to the signed DW-bit range.
- R9: I and Q are scaled by the same gain derived from the same table entry.
- R10: A sample accepted at rising edge k appears with `out_valid`=1 just after edge k+3. `out_valid` is high for exactly one cycle per accepted sample, and back-to-back samples give back-to-back outputs.
- R11: `att_out` changes only in cycles where `out_valid` is 1. It always shows the attenuator code of the same entry that scaled the sample on `out_i`/`out_q`.
- R12: The gain index, mode and external term are captured with each sample, so an index change takes effect on exactly the sample that carries it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | Input I sample, signed |
| in_q | input | DW | Input Q sample, signed |
| gain_idx | input | IDX_W | Receive gain index for this sample |
| mode | input | 1 | 0 = trim mode, 1 = cancel mode |
| ext_hdb | input | EXT_W | External gain to cancel, half-dB units |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | IDX_W | Table write index |
| wr_att | input | ATT_W | Attenuator code to store |
| wr_trim | input | TRIM_W | Signed trim to store, half-dB units |
| tbl_ready | output | 1 | Table filled; samples accepted |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DW | Scaled I sample, signed |
| out_q | output | DW | Scaled Q sample, signed |
| att_out | output | ATT_W | Attenuator code paired with the output sample |

## Verification
The bench builds the block with DW=16, IDX_W=4, ATT_W=6, TRIM_W=4 and EXT_W=8. The 16-entry table makes the refill after reset short enough to count edge by edge. The 8-bit external term can push the cancel-mode gain past the upper clamp of 167 half-dB steps, which the default width cannot reach. With a 16-bit datapath, full-scale inputs at a few dB of gain hit both saturation rails. The top index paired with a trim of -8 gives a negative gain, which exercises the downward shift.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  localparam int MANT_W        = 16;
  localparam int MANT_FRAC     = 14;
  localparam int STEPS_PER_OCT = 12;
  localparam int NEG_OCT       = 2;
  localparam int G_MIN         = -STEPS_PER_OCT * NEG_OCT;
  localparam int G_MAX         = STEPS_PER_OCT * MANT_FRAC - 1;
  localparam int SH_BASE       = MANT_FRAC + NEG_OCT;
  localparam int SH_W          = 5;

  typedef enum logic {GM_TRIM = 1'b0, GM_CANCEL = 1'b1} gmode_e;

  // 2^(r/12) in unsigned Q2.14
  function automatic logic [MANT_W-1:0] mant_of(input logic [3:0] r);
    case (r)
      4'd0:    mant_of = 16'd16384;
      4'd1:    mant_of = 16'd17358;
      4'd2:    mant_of = 16'd18390;
      4'd3:    mant_of = 16'd19484;
      4'd4:    mant_of = 16'd20643;
      4'd5:    mant_of = 16'd21870;
      4'd6:    mant_of = 16'd23170;
      4'd7:    mant_of = 16'd24548;
      4'd8:    mant_of = 16'd26008;
      4'd9:    mant_of = 16'd27554;
      4'd10:   mant_of = 16'd29193;
      default: mant_of = 16'd30929;
    endcase
  endfunction
endpackage

// File: rtl/rgc_table.sv
module rgc_table #(
  parameter int IDX_W  = 6,
  parameter int ATT_W  = 6,
  parameter int TRIM_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_hold,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [ATT_W-1:0]  wr_att,
  input  logic [TRIM_W-1:0] wr_trim,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [ATT_W-1:0]  rd_att,
  output logic [TRIM_W-1:0] rd_trim,
  output logic              ready
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int EW    = ATT_W + TRIM_W;

  logic [EW-1:0]    mem [DEPTH];
  logic [EW-1:0]    rd_q;
  logic [IDX_W-1:0] fill_ptr;
  logic             we;
  logic [IDX_W-1:0] wa;
  logic [EW-1:0]    wd;

  // refill walker owns the write port until the table is complete
  always_comb begin
    if (!ready) begin
      we = 1'b1;
      wa = fill_ptr;
      wd = {ATT_W'(DEPTH - 1 - int'(fill_ptr)), TRIM_W'(0)};
    end else begin
      we = wr_en && !wr_hold;
      wa = wr_addr;
      wd = {wr_att, wr_trim};
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (rd_en) rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_ptr <= '0;
      ready    <= 1'b0;
    end else if (!ready) begin
      fill_ptr <= fill_ptr + 1'b1;
      if (fill_ptr == IDX_W'(DEPTH - 1)) ready <= 1'b1;
    end
  end

  assign rd_att  = rd_q[EW-1:TRIM_W];
  assign rd_trim = rd_q[TRIM_W-1:0];

  p_fill_done_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(fill_ptr) == IDX_W'(DEPTH - 1));
  p_ready_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
endmodule

// File: rtl/rgc_gain_calc.sv
module rgc_gain_calc
  import rgc_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TRIM_W = 4,
  parameter int EXT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  gmode_e            mode,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TRIM_W-1:0] trim,
  input  logic [EXT_W-1:0]  ext,
  output logic [SH_W-1:0]   sh,
  output logic [MANT_W-1:0] mant
);
  localparam int IDX_MAX = (1 << IDX_W) - 1;

  int g_raw, g_clip, g_ofs, oct, rem;
  logic [SH_W-1:0]   sh_c;
  logic [MANT_W-1:0] mant_c;

  always_comb begin
    g_raw = int'($signed(trim));
    if (mode == GM_CANCEL) g_raw = g_raw + (IDX_MAX - int'(idx)) + int'(ext);
    if (g_raw < G_MIN)      g_clip = G_MIN;
    else if (g_raw > G_MAX) g_clip = G_MAX;
    else                    g_clip = g_raw;
    g_ofs  = g_clip - G_MIN;
    oct    = g_ofs / STEPS_PER_OCT;
    rem    = g_ofs % STEPS_PER_OCT;
    sh_c   = SH_W'(SH_BASE - oct);
    mant_c = mant_of(4'(rem));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= SH_W'(SH_BASE);
      mant <= mant_of(4'd0);
    end else if (en) begin
      sh   <= sh_c;
      mant <= mant_c;
    end
  end

  p_shift_range_r7: assert property (@(posedge clk) disable iff (rst)
    en |=> (sh >= SH_W'(1)) && (sh <= SH_W'(SH_BASE)));
  p_mant_norm_r7: assert property (@(posedge clk) disable iff (rst)
    en |=> mant >= mant_of(4'd0));
endmodule

// File: rtl/rgc_scaler.sv
module rgc_scaler
  import rgc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [DW-1:0] x,
  input  logic [MANT_W-1:0]    mant,
  input  logic [SH_W-1:0]      sh,
  output logic signed [DW-1:0] y
);
  localparam int PW = DW + MANT_W + 1;
  localparam int XW = PW + 1;
  localparam logic signed [XW-1:0] YMAX = XW'((2 ** (DW - 1)) - 1);
  localparam logic signed [XW-1:0] YMIN = XW'(-(2 ** (DW - 1)));

  logic signed [PW-1:0] xa, ma, p_q;
  logic [SH_W-1:0]      sh_q;
  logic                 v_q;
  logic signed [XW-1:0] p_ext, bias, rnd, sat_c;

  assign xa = {{(PW - DW){x[DW-1]}}, x};
  assign ma = {{(PW - MANT_W){1'b0}}, mant};

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q  <= '0;
      sh_q <= SH_W'(1);
      v_q  <= 1'b0;
    end else begin
      p_q  <= xa * ma;
      sh_q <= sh;
      v_q  <= v_in;
    end
  end

  always_comb begin
    p_ext = {p_q[PW-1], p_q};
    bias  = XW'(1) << (sh_q - SH_W'(1));
    rnd   = (p_ext + bias) >>> sh_q;
    if (rnd > YMAX)      sat_c = YMAX;
    else if (rnd < YMIN) sat_c = YMIN;
    else                 sat_c = rnd;
  end

  always_ff @(posedge clk) begin
    if (rst)      y <= '0;
    else if (v_q) y <= sat_c[DW-1:0];
  end

  p_sign_pos_r8: assert property (@(posedge clk) disable iff (rst)
    (v_q && p_q >= 0) |=> y >= 0);
  p_sign_neg_r8: assert property (@(posedge clk) disable iff (rst)
    (v_q && p_q < 0) |=> y <= 0);
endmodule

// File: rtl/rx_gain_comp.sv
module rx_gain_comp
  import rgc_pkg::*;
#(
  parameter int DW     = 16,
  parameter int IDX_W  = 6,
  parameter int ATT_W  = 6,
  parameter int TRIM_W = 4,
  parameter int EXT_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [IDX_W-1:0]     gain_idx,
  input  logic                 mode,
  input  logic [EXT_W-1:0]     ext_hdb,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_addr,
  input  logic [ATT_W-1:0]     wr_att,
  input  logic [TRIM_W-1:0]    wr_trim,
  output logic                 tbl_ready,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic [ATT_W-1:0]     att_out
);
  localparam int LANES = 2;

  logic                 acc;
  logic                 v1, v2, v3;
  logic [IDX_W-1:0]     idx1;
  gmode_e               mode1;
  logic [EXT_W-1:0]     ext1;
  logic signed [DW-1:0] s1_x [LANES];
  logic signed [DW-1:0] s2_x [LANES];
  logic signed [DW-1:0] y_l  [LANES];
  logic signed [DW-1:0] x_in [LANES];
  logic [ATT_W-1:0]     tbl_att, att2, att3;
  logic [TRIM_W-1:0]    tbl_trim;
  logic [SH_W-1:0]      sh2;
  logic [MANT_W-1:0]    mant2;

  assign acc     = in_valid && tbl_ready;
  assign x_in[0] = in_i;
  assign x_in[1] = in_q;

  rgc_table #(.IDX_W(IDX_W), .ATT_W(ATT_W), .TRIM_W(TRIM_W)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_hold(in_valid), .wr_addr(wr_addr),
    .wr_att(wr_att), .wr_trim(wr_trim),
    .rd_en(acc), .rd_addr(gain_idx),
    .rd_att(tbl_att), .rd_trim(tbl_trim),
    .ready(tbl_ready)
  );

  // stage 1: capture sample with its own index, mode and external term
  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      idx1  <= '0;
      mode1 <= GM_TRIM;
      ext1  <= '0;
    end else begin
      v1 <= acc;
      if (acc) begin
        idx1  <= gain_idx;
        mode1 <= gmode_e'(mode);
        ext1  <= ext_hdb;
      end
    end
  end

  rgc_gain_calc #(.IDX_W(IDX_W), .TRIM_W(TRIM_W), .EXT_W(EXT_W)) u_gc (
    .clk(clk), .rst(rst), .en(v1), .mode(mode1), .idx(idx1),
    .trim(tbl_trim), .ext(ext1), .sh(sh2), .mant(mant2)
  );

  // stage 2/3 side band: attenuator code travels with the sample
  always_ff @(posedge clk) begin
    if (rst) begin
      v2      <= 1'b0;
      v3      <= 1'b0;
      att2    <= '0;
      att3    <= '0;
      att_out <= '0;
    end else begin
      v2 <= v1;
      v3 <= v2;
      if (v1) att2 <= tbl_att;
      if (v2) att3 <= att2;
      if (v3) att_out <= att3;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v3;
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_x[ln] <= '0;
        s2_x[ln] <= '0;
      end else begin
        if (acc) s1_x[ln] <= x_in[ln];
        if (v1)  s2_x[ln] <= s1_x[ln];
      end
    end

    rgc_scaler #(.DW(DW)) u_sc (
      .clk(clk), .rst(rst), .v_in(v2), .x(s2_x[ln]),
      .mant(mant2), .sh(sh2), .y(y_l[ln])
    );
  end

  assign out_i = y_l[0];
  assign out_q = y_l[1];

  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(acc, 4));
  p_att_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(att_out));
  p_pair_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> att_out == $past(tbl_att, 3));
  p_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !tbl_ready |=> !v1);
endmodule

// File: tb/sim_rx_gain_comp.sv
module sim_rx_gain_comp;
  localparam int DW = 16, IDX_W = 4, ATT_W = 6, TRIM_W = 4, EXT_W = 8;
  localparam int DEPTH = 1 << IDX_W;
  localparam int M [12] = '{16384, 17358, 18390, 19484, 20643, 21870,
                            23170, 24548, 26008, 27554, 29193, 30929};

  typedef struct packed {
    logic               md;
    logic [3:0]         idx;
    logic [7:0]         ext;
    logic signed [15:0] xi;
    logic signed [15:0] xq;
    logic [3:0]         req;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b0, 4'd4,  8'd0,   16'sd1000,   -16'sd1000,  4'd5},  // R5 zero trim
    '{1'b0, 4'd3,  8'd9,   16'sd10000,  -16'sd7,     4'd5},  // R5 ext ignored
    '{1'b0, 4'd7,  8'd0,   -16'sd12345, 16'sd4321,   4'd5},  // R5 negative trim
    '{1'b1, 4'd15, 8'd0,   16'sd30000,  -16'sd30000, 4'd6},  // R6 net negative
    '{1'b1, 4'd0,  8'd0,   16'sd1200,   -16'sd1201,  4'd6},  // R6
    '{1'b1, 4'd9,  8'd20,  16'sd500,    -16'sd250,   4'd6},  // R6 external term
    '{1'b1, 4'd5,  8'd255, 16'sd1,      -16'sd1,     4'd7},  // R7 upper clamp
    '{1'b1, 4'd12, 8'd12,  16'sd32767,  -16'sd32768, 4'd8},  // R8 saturation
    '{1'b1, 4'd4,  8'd0,   16'sd3,      -16'sd3,     4'd8},  // R8 rounding
    '{1'b0, 4'd1,  8'd0,   -16'sd32768, 16'sd32767,  4'd9},  // R9 full scale
    '{1'b1, 4'd15, 8'd8,   16'sd777,    -16'sd778,   4'd6}   // R6 unity
  };

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, mode = 1'b0, wr_en = 1'b0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic [IDX_W-1:0] gain_idx = '0, wr_addr = '0;
  logic [EXT_W-1:0] ext_hdb = '0;
  logic [ATT_W-1:0] wr_att = '0;
  logic [TRIM_W-1:0] wr_trim = '0;
  logic tbl_ready, out_valid;
  logic signed [DW-1:0] out_i, out_q;
  logic [ATT_W-1:0] att_out;

  int checks = 0, errors = 0;
  int sh_att [DEPTH];
  int sh_trim [DEPTH];

  always #10 clk = ~clk;

  rx_gain_comp #(.DW(DW), .IDX_W(IDX_W), .ATT_W(ATT_W), .TRIM_W(TRIM_W), .EXT_W(EXT_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .gain_idx(gain_idx), .mode(mode), .ext_hdb(ext_hdb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_att(wr_att), .wr_trim(wr_trim),
    .tbl_ready(tbl_ready), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .att_out(att_out)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic void shadow_defaults();
    for (int n = 0; n < DEPTH; n++) begin
      sh_att[n]  = DEPTH - 1 - n;
      sh_trim[n] = 0;
    end
  endfunction

  function automatic int gain_of(bit md, int idx, int ext);
    int g = sh_trim[idx];
    if (md) g = g + (DEPTH - 1 - idx) + ext;
    if (g < -24) g = -24;
    if (g > 167) g = 167;
    return g;
  endfunction

  function automatic int scale(int x, int g);
    int go = g + 24;
    int s = 16 - go / 12;
    longint p = longint'(x) * M[go % 12];
    longint y = (p + (longint'(1) << (s - 1))) >>> s;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  task automatic tbl_write(int a, int att, int trim);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = IDX_W'(a); wr_att = ATT_W'(att); wr_trim = TRIM_W'(trim);
    @(negedge clk);
    wr_en = 1'b0;
    sh_att[a] = att; sh_trim[a] = trim;
  endtask

  task automatic drive(bit md, int idx, int ext, int xi, int xq);
    mode = md; gain_idx = IDX_W'(idx); ext_hdb = EXT_W'(ext);
    in_i = DW'(xi); in_q = DW'(xq); in_valid = 1'b1;
  endtask

  task automatic expect_out(string req, bit md, int idx, int ext, int xi, int xq);
    int g = gain_of(md, idx, ext);
    check("R10", "out_valid", int'(out_valid), 1);
    check(req, "out_i", int'(out_i), scale(xi, g));
    check("R9", "out_q", int'(out_q), scale(xq, g));
    check("R11", "att_out", int'(att_out), sh_att[idx]);
  endtask

  task automatic run_one(string req, bit md, int idx, int ext, int xi, int xq);
    @(negedge clk);
    drive(md, idx, ext, xi, xq);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    expect_out(req, md, idx, ext, xi, xq);
    @(negedge clk);
    check("R10", "out_valid single cycle", int'(out_valid), 0);
  endtask

  task automatic do_reset_and_fill();
    int cnt = 0;
    int seen = 0;
    rst = 1'b1; in_valid = 1'b0;
    repeat (8) @(negedge clk);
    // R1 reset state
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "out_i in reset", int'(out_i), 0);
    check("R1", "att_out in reset", int'(att_out), 0);
    check("R1", "tbl_ready in reset", int'(tbl_ready), 0);
    rst = 1'b0;
    drive(1'b0, 0, 0, 1234, 1234);  // R3 samples offered during refill
    while (!tbl_ready && cnt < 4 * DEPTH) begin
      @(negedge clk);
      cnt++;
      if (out_valid) seen++;
      if (tbl_ready) in_valid = 1'b0;
    end
    check("R2", "edges until tbl_ready", cnt, DEPTH);
    repeat (6) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    check("R3", "outputs from gated samples", seen, 0);
    shadow_defaults();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    finish_run();
  end

  initial begin
    do_reset_and_fill();
    run_one("R2", 1'b0, 6, 0, 4321, -4321);  // R2 default entry

    // R4 writes while idle take effect
    tbl_write(3, 5, 2);
    tbl_write(7, 40, -3);
    tbl_write(15, 0, -8);
    tbl_write(0, 63, 7);

    for (int v = 0; v < 11; v++) begin
      string rq;
      rq = $sformatf("R%0d", int'(VECS[v].req));
      run_one(rq, VECS[v].md, int'(VECS[v].idx), int'(VECS[v].ext),
              int'(VECS[v].xi), int'(VECS[v].xq));
    end

    // R4 write presented together with a sample is dropped
    @(negedge clk);
    drive(1'b0, 2, 0, 6000, -6000);
    wr_en = 1'b1; wr_addr = 4'd2; wr_att = 6'd9; wr_trim = 4'd5;
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R4", 1'b0, 2, 0, 6000, -6000);
    run_one("R4", 1'b0, 2, 0, -300, 300);
    check("R4", "entry 2 att after blocked write", int'(att_out), 13);

    // R12 / R11 back-to-back samples with an index change on every sample
    begin
      int sidx [5] = '{3, 7, 0, 15, 9};
      int sxi  [5] = '{1000, -2000, 3000, -4000, 5000};
      for (int c = 0; c < 9; c++) begin
        @(negedge clk);
        if (c >= 4) expect_out("R12", 1'b1, sidx[c-4], 4, sxi[c-4], -sxi[c-4] / 2);
        if (c < 5) drive(1'b1, sidx[c], 4, sxi[c], -sxi[c] / 2);
        else in_valid = 1'b0;
      end
      @(negedge clk);
      check("R10", "out_valid after stream", int'(out_valid), 0);
    end

    // R2 reset restores the default table
    do_reset_and_fill();
    run_one("R2", 1'b0, 3, 0, 5000, -5000);
    check("R2", "entry 3 att after reset", int'(att_out), 12);

    finish_run();
  end
endmodule